// File: doc/BRIEF.md
# Signaling Change Stack Readout

This block sits beside the receive signaling path of a 32-slot TDM framer. It watches the per-channel ABCD signaling updates and records only the changes. Each update is presented once per channel, after that channel's D bit has settled. It carries the newly received nibble and the nibble currently held in that channel's output buffer. When the two differ, the block drives an update strobe so the external output buffer takes the new value. If the channel's stack-enable bit is also set, the block queues the channel number and the new nibble in a 32-entry first-in first-out store.

At each multiframe boundary, a sticky interrupt is raised if any enabled channel changed during that multiframe. The host then drains the queue through one register address. Reads alternate between a channel word and a value word. Each word carries a word-ID bit and a more-data flag, so the host stops as soon as a value word reports that nothing further is waiting. A status register reports the interrupt and a sticky overflow flag, and reading it clears both.

Top module: `sigstk_top`

## Requirements
- R1: After reset the store is empty, `irq` is 0, the status register (address 5) reads 0x00, all four enable registers (addresses 0 to 3) read 0x00, and the next read of the stack address (address 4) returns a channel word.
- R2: Enable register k (address k, k = 0..3) holds the enable bits of channels 8k..8k+7, with bit i for channel 8k+i, and reads back as written. Only changes on enabled channels are queued.
- R3: An update with `evt_valid` = 1 and `evt_new` different from `evt_cur` drives `upd_valid` = 1 in the same cycle, with `upd_chan` = `evt_chan` and `upd_abcd` = `evt_new`, whether or not the channel is enabled. An update with equal nibbles drives `upd_valid` = 0 and queues nothing.
- R4: While `t1_mode` = 1, updates for channel 0 or for channels above 24 have no effect: no update strobe and no entry. Channels 1 to 24 behave normally.
- R5: The first read of a pair returns the channel word: bit7 = 0, bit6 = 1, bit5 = 0, bits4:0 = channel number.
- R6: The second read returns the value word: bit7 = 1, bits5:4 = 0, bits3:0 = ABCD with A in bit3 and D in bit0. Bit6 (MORE) is 1 when further entries remain after this one and 0 otherwise. The entry is removed after this read.
- R7: Entries are read out oldest first.
- R8: A read of the stack address while the store is empty returns 0x80. It removes nothing, and the following read is again a channel word.
- R9: The store holds 32 entries. An enabled change that arrives while the store is full, with no removal in the same cycle, is dropped and sets status bit1 (overflow).
- R10: At a cycle with `mf_end` = 1, status bit0 (interrupt) is set if at least one enabled change arrived since the previous boundary, including that cycle. Otherwise it is left unchanged. Reading the status register returns {6'b0, overflow, interrupt} and then clears both bits.
- R11: When an entry is added in the same cycle as a value-word read removes one, both take effect and nothing is dropped, even with the store full.
- R12: The `irq` output follows status bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t1_mode | input | 1 | 1 = 24-channel mode (channels 1..24 valid) |
| evt_valid | input | 1 | Per-channel signaling update present |
| evt_chan | input | 5 | Channel of the update |
| evt_new | input | 4 | Newly received ABCD nibble |
| evt_cur | input | 4 | ABCD nibble currently in the output buffer |
| mf_end | input | 1 | Multiframe boundary pulse |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| irq | output | 1 | Sticky signaling interrupt |
| upd_valid | output | 1 | Write strobe for the output signaling buffer |
| upd_chan | output | 5 | Channel to update |
| upd_abcd | output | 4 | New ABCD nibble for the buffer |

## Verification
Several internal faults would surface at the host port within one read pair. A lost or extra entry shows up at once as a wrong channel number or ABCD nibble. A wrong occupancy shows up as a MORE flag that stops the drain early or lets it run past the end, or as an overflow flag that appears one entry too soon or too late. A stuck read-word toggle swaps channel and value words, which the word-ID bit exposes on the very next read. A pending flag that is not cleared at a boundary raises `irq` one multiframe later with no change behind it.

// File: rtl/sigstk_pkg.sv
package sigstk_pkg;

  localparam int CH_W   = 5;
  localparam int SIG_W  = 4;
  localparam int WORD_W = 8;

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic [SIG_W-1:0] abcd;
  } stk_entry_t;

  // channel word: id=0, more=1, pad, channel
  function automatic logic [WORD_W-1:0] chan_word(input logic [CH_W-1:0] ch);
    return {1'b0, 1'b1, 1'b0, ch};
  endfunction

  // value word: id=1, more flag, pad, A..D
  function automatic logic [WORD_W-1:0] value_word(input logic more,
                                                   input logic [SIG_W-1:0] abcd);
    return {1'b1, more, 2'b00, abcd};
  endfunction

  function automatic logic [WORD_W-1:0] empty_word();
    return value_word(1'b0, '0);
  endfunction

  // channel number legal for the current line mode
  function automatic logic chan_legal(input logic t1, input logic [CH_W-1:0] ch,
                                      input int t1_last);
    if (t1) return (ch != '0) && (int'(ch) <= t1_last);
    return 1'b1;
  endfunction

endpackage

// File: rtl/sigstk_detect.sv
module sigstk_detect
  import sigstk_pkg::*;
#(
  parameter int NCH     = 32,
  parameter int T1_LAST = 24
) (
  input  logic             t1_mode,
  input  logic             evt_valid,
  input  logic [CH_W-1:0]  evt_chan,
  input  logic [SIG_W-1:0] evt_new,
  input  logic [SIG_W-1:0] evt_cur,
  input  logic [NCH-1:0]   en_vec,
  output logic             chg,
  output logic             push_req,
  output stk_entry_t       push_ent
);

  logic legal;
  logic enabled;

  assign legal = chan_legal(t1_mode, evt_chan, T1_LAST) && (int'(evt_chan) < NCH);

  always_comb begin
    enabled = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(evt_chan) == i) enabled = en_vec[i];
    end
  end

  assign chg           = evt_valid && legal && (evt_new != evt_cur);
  assign push_req      = chg && enabled;
  assign push_ent.ch   = evt_chan;
  assign push_ent.abcd = evt_new;

endmodule

// File: rtl/sigstk_fifo.sv
module sigstk_fifo
  import sigstk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int OCC_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  stk_entry_t       push_ent,
  input  logic             pop,
  output logic             push_ok,
  output logic             push_drop,
  output stk_entry_t       head,
  output logic             empty,
  output logic [OCC_W-1:0] occ
);

  localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  stk_entry_t        mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              room;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (occ == '0);
  assign room      = (occ < FULL_CNT) || pop;
  assign push_ok   = push_req && room;
  assign push_drop = push_req && !room;
  assign head      = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop)     rptr <= bump(rptr);
      occ <= occ + OCC_W'(push_ok) - OCC_W'(pop);
    end
  end

endmodule

// File: rtl/sigstk_reader.sv
module sigstk_reader
  import sigstk_pkg::*;
#(
  parameter int OCC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stack,
  input  logic              empty,
  input  logic [OCC_W-1:0]  occ,
  input  stk_entry_t        head,
  output logic              pop,
  output logic [WORD_W-1:0] word
);

  logic val_phase;
  logic more;

  assign more = (occ > OCC_W'(1));
  assign pop  = rd_stack && val_phase && !empty;

  always_comb begin
    if (!val_phase) word = empty ? empty_word() : chan_word(head.ch);
    else            word = value_word(more, head.abcd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_phase <= 1'b0;
    end else if (rd_stack) begin
      if (val_phase)   val_phase <= 1'b0;
      else if (!empty) val_phase <= 1'b1;
    end
  end

endmodule

// File: rtl/sigstk_top.sv
module sigstk_top
  import sigstk_pkg::*;
#(
  parameter int NCH     = 32,
  parameter int DEPTH   = 32,
  parameter int T1_LAST = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        t1_mode,
  input  logic        evt_valid,
  input  logic [4:0]  evt_chan,
  input  logic [3:0]  evt_new,
  input  logic [3:0]  evt_cur,
  input  logic        mf_end,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        irq,
  output logic        upd_valid,
  output logic [4:0]  upd_chan,
  output logic [3:0]  upd_abcd
);

  localparam int AW        = $clog2(DEPTH);
  localparam int OCC_W     = AW + 1;
  localparam int NEN_REG   = NCH / 8;
  localparam int EN_AW     = $clog2(NEN_REG);
  localparam logic [2:0] ADDR_STACK = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  logic [NCH-1:0]    en_vec;
  logic [7:0]        en_byte [NEN_REG];
  logic              chg, push_req, push_ok, push_drop, pop, empty;
  logic              rd_stack, rd_stat;
  logic [OCC_W-1:0]  occ;
  stk_entry_t        push_ent, head;
  logic [WORD_W-1:0] stk_word;
  logic              pend, ovf;

  assign rd_stack = host_rd && (host_addr == ADDR_STACK);
  assign rd_stat  = host_rd && (host_addr == ADDR_STAT);

  for (genvar g = 0; g < NEN_REG; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n) en_byte[g] <= '0;
      else if (host_wr && (host_addr == 3'(g))) en_byte[g] <= host_wdata;
    end
    assign en_vec[g*8 +: 8] = en_byte[g];
  end

  sigstk_detect #(.NCH(NCH), .T1_LAST(T1_LAST)) u_det (
    .t1_mode  (t1_mode),
    .evt_valid(evt_valid),
    .evt_chan (evt_chan),
    .evt_new  (evt_new),
    .evt_cur  (evt_cur),
    .en_vec   (en_vec),
    .chg      (chg),
    .push_req (push_req),
    .push_ent (push_ent)
  );

  sigstk_fifo #(.DEPTH(DEPTH), .AW(AW), .OCC_W(OCC_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .push_ent (push_ent),
    .pop      (pop),
    .push_ok  (push_ok),
    .push_drop(push_drop),
    .head     (head),
    .empty    (empty),
    .occ      (occ)
  );

  sigstk_reader #(.OCC_W(OCC_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stack(rd_stack),
    .empty   (empty),
    .occ     (occ),
    .head    (head),
    .pop     (pop),
    .word    (stk_word)
  );

  assign upd_valid = chg;
  assign upd_chan  = evt_chan;
  assign upd_abcd  = evt_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      irq  <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (mf_end)        pend <= 1'b0;
      else if (push_req) pend <= 1'b1;

      if (mf_end && (pend || push_req)) irq <= 1'b1;
      else if (rd_stat)                 irq <= 1'b0;

      if (push_drop)    ovf <= 1'b1;
      else if (rd_stat) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (int'(host_addr) < NEN_REG) host_rdata <= en_byte[host_addr[EN_AW-1:0]];
      else if (rd_stack)             host_rdata <= stk_word;
      else if (rd_stat)              host_rdata <= {6'b0, ovf, irq};
      else                           host_rdata <= '0;
    end
  end

endmodule

// File: rtl/sigstk_chk.sv
module sigstk_chk #(
  parameter int DEPTH = 32,
  parameter int OCC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic [3:0]       evt_new,
  input logic [3:0]       evt_cur,
  input logic             push_req,
  input logic             push_ok,
  input logic             pop,
  input logic [OCC_W-1:0] occ,
  input logic             irq,
  input logic             mf_end
);

  a_r9_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  a_r9_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && (occ == OCC_W'(DEPTH)) && !pop) |-> !push_ok);

  a_r3_same_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_new == evt_cur)) |-> !push_req);

  a_r11_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop) |=> (occ == $past(occ) + 1'b1));

  a_r11_push_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop) |=> $stable(occ));

  a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ != '0));

  a_r10_irq_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mf_end));

endmodule

bind sigstk_top sigstk_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_valid(evt_valid),
  .evt_new  (evt_new),
  .evt_cur  (evt_cur),
  .push_req (push_req),
  .push_ok  (push_ok),
  .pop      (pop),
  .occ      (occ),
  .irq      (irq),
  .mf_end   (mf_end)
);

// File: tb/sim_sigstk_top.sv
module sim_sigstk_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       t1_mode = 1'b0;
  logic       evt_valid = 1'b0;
  logic [4:0] evt_chan = '0;
  logic [3:0] evt_new = '0;
  logic [3:0] evt_cur = '0;
  logic       mf_end = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq, upd_valid;
  logic [4:0] upd_chan;
  logic [3:0] upd_abcd;

  always #5 clk = ~clk;

  sigstk_top u0 (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // bench model of the queue
  logic [4:0] m_ch [64];
  logic [3:0] m_v  [64];
  int m_head = 0, m_cnt = 0;
  localparam int CAP = 32;
  localparam logic [2:0] A_STK = 3'd4, A_STAT = 3'd5;

  // vector: channel, new, current, expect queued
  localparam logic [13:0] VEC [8] = '{
    {5'd3,  4'hA, 4'h5, 1'b1},
    {5'd3,  4'h7, 4'h7, 1'b0},
    {5'd31, 4'h1, 4'h0, 1'b0},
    {5'd0,  4'hF, 4'h0, 1'b1},
    {5'd17, 4'h6, 4'h2, 1'b1},
    {5'd9,  4'h4, 4'h4, 1'b0},
    {5'd24, 4'hC, 4'h3, 1'b1},
    {5'd12, 4'h0, 4'h8, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic void m_push(input logic [4:0] ch, input logic [3:0] v);
    if (m_cnt < CAP) begin
      m_ch[(m_head + m_cnt) % 64] = ch;
      m_v[(m_head + m_cnt) % 64]  = v;
      m_cnt++;
    end
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic evt(input logic [4:0] ch, input logic [3:0] nv, input logic [3:0] cv,
                     input logic exp_upd, input string req);
    @(negedge clk); evt_valid = 1; evt_chan = ch; evt_new = nv; evt_cur = cv;
    #1;
    chk(req, {7'b0, upd_valid}, {7'b0, exp_upd});
    if (exp_upd) chk(req, {upd_chan, 3'b0}, {ch, 3'b0});
    @(negedge clk); evt_valid = 0;
  endtask

  task automatic mf();
    @(negedge clk); mf_end = 1;
    @(negedge clk); mf_end = 0;
  endtask

  // read one pair and compare against the model head
  task automatic drain_one(input string req);
    logic [7:0] d;
    logic more;
    rd(A_STK, d);
    chk({req, " R5 chan word"}, d, {3'b010, m_ch[m_head]});
    rd(A_STK, d);
    more = (m_cnt > 1);
    chk({req, " R6 value word"}, d, {1'b1, more, 2'b00, m_v[m_head]});
    m_head = (m_head + 1) % 64; m_cnt--;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(A_STAT, d); chk("R1 status", d, 8'h00);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), d); chk("R1 enable reg", d, 8'h00);
    end
    rd(A_STK, d); chk("R1 R8 empty read", d, 8'h80);
    evt(5'd2, 4'h3, 4'h1, 1'b1, "R2 disabled upd");
    rd(A_STK, d); chk("R2 disabled not queued", d, 8'h80);

    // R2: enables, channel 31 left off
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'h7F);
    rd(3'd3, d); chk("R2 enable readback", d, 8'h7F);
    rd(3'd1, d); chk("R2 enable readback", d, 8'hFF);

    // vector walk: R3 update strobe, R2/R3 queueing
    for (int i = 0; i < 8; i++) begin
      logic [4:0] ch; logic [3:0] nv, cv; logic q;
      {ch, nv, cv, q} = VEC[i];
      evt(ch, nv, cv, (nv != cv), "R3 update strobe");
      if (q) m_push(ch, nv);
    end
    chk("R10 irq before boundary", {7'b0, irq}, 8'h00);
    mf();
    chk("R12 irq pin", {7'b0, irq}, 8'h01);
    // R7: oldest first
    while (m_cnt > 0) drain_one("R7");
    rd(A_STK, d); chk("R8 empty after drain", d, 8'h80);
    rd(A_STK, d); chk("R8 toggle held", d, 8'h80);
    rd(A_STAT, d); chk("R10 status irq", d, 8'h01);
    rd(A_STAT, d); chk("R10 status cleared", d, 8'h00);
    chk("R12 irq cleared", {7'b0, irq}, 8'h00);
    mf();
    chk("R10 no change no irq", {7'b0, irq}, 8'h00);

    // R4: 24-channel mode
    t1_mode = 1;
    evt(5'd0,  4'h9, 4'h1, 1'b0, "R4 ch0 ignored");
    evt(5'd25, 4'h9, 4'h1, 1'b0, "R4 ch25 ignored");
    evt(5'd1,  4'h9, 4'h1, 1'b1, "R4 ch1 kept");
    m_push(5'd1, 4'h9);
    t1_mode = 0;
    drain_one("R4");
    rd(A_STK, d); chk("R4 only one entry", d, 8'h80);

    // R9: overflow
    for (int i = 0; i < 33; i++) begin
      evt(5'(i % 31), 4'(i), 4'(i) ^ 4'h8, 1'b1, "R9 fill");
      m_push(5'(i % 31), 4'(i));
    end
    rd(A_STAT, d); chk("R9 overflow flag", d, 8'h02);
    while (m_cnt > 0) drain_one("R9");
    rd(A_STK, d); chk("R9 empty after 32", d, 8'h80);
    mf();
    rd(A_STAT, d); chk("R10 pending from fill", d, 8'h01);

    // R11: push with pop while full
    for (int i = 0; i < 32; i++) begin
      evt(5'(i % 31), 4'(i + 3), 4'(i + 3) ^ 4'h1, 1'b1, "R11 fill");
      m_push(5'(i % 31), 4'(i + 3));
    end
    rd(A_STK, d); chk("R11 chan word", d, {3'b010, m_ch[m_head]});
    @(negedge clk);
    host_rd = 1; host_addr = A_STK;
    evt_valid = 1; evt_chan = 5'd7; evt_new = 4'h9; evt_cur = 4'h0;
    @(negedge clk);
    host_rd = 0; evt_valid = 0; d = host_rdata;
    chk("R11 value word while full", d, {2'b11, 2'b00, m_v[m_head]});
    m_head = (m_head + 1) % 64; m_cnt--;
    m_push(5'd7, 4'h9);
    rd(A_STAT, d); chk("R11 no overflow", d, 8'h00);
    while (m_cnt > 0) drain_one("R11");
    rd(A_STK, d); chk("R11 empty at end", d, 8'h80);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule